// File: doc/BRIEF.md
# Asynchronous Handshake Bus Master Sequencer

This block carries out one transfer at a time on a 16-bit asynchronous-handshake bus, acting as the master. An internal client gives it a request: address, function code, direction, size (byte or word) and, for writes, the data. The block then drives the external bus through a fixed series of numbered phases. It waits for the slave to answer with an acknowledge or a bus error. It finishes by returning the read data together with a one-cycle done or error pulse.

The block runs on a system clock at twice the bus clock, so each system clock period is one numbered half-bus-clock phase. A normal cycle uses phases S0 to S7. Whole bus clocks of wait time (pairs of phases) are added after S4 until a response arrives. A bus error that comes without an acknowledge adds two more phases, S8 and S9.

The phase index below counts system clocks from S0 (index 0). `n` is the number of wait pairs that were added. Strobes are active-low.

Top module: `hsbus_master`

## Requirements
- R1: After reset and while idle, `as_n`, `uds_n` and `lds_n` are 1, `addr_oe`, `dout_oe`, `done` and `err` are 0, `rw_o` is 1 and `ready` is 1.
- R2: A request (`req_valid` high on a clock edge) is accepted only while `ready` is 1. The first phase S0 follows on the next clock. A request raised while a cycle is under way has no effect: the address on the bus is unchanged, and no second cycle follows.
- R3: In S0, `fc_o` shows the request's function code and `rw_o` is 1 for a read and 0 for a write. `addr_oe` is 1 from index 1 up to the last phase of the cycle, and 0 in S0 and while idle.
- R4: `as_n` is 0 from index 2 through index 6+2n, and 1 again from S7 (index 7+2n) onward.
- R5: When the strobes are active, a word access drives both `uds_n` and `lds_n` low. A byte access with address bit 0 equal to 0 drives only `uds_n` low. A byte access with address bit 0 equal to 1 drives only `lds_n` low.
- R6: The active-low inputs `bus_ack_n` and `bus_err_n` are looked at on the clock edge that ends S4, and on the edge that ends every second wait phase. Each look that finds neither input active adds two phases.
- R7: On a read, `rdata` takes the `din` value present on the edge that ends S6. It keeps that value while `done` is high and afterwards. `done` is high for exactly one clock, at index 7+2n.
- R8: A bus error seen without an acknowledge sends the cycle through S8 and S9. `err` is then high for one clock at index 9+2n, and `done` stays low. If both inputs are active on the same sample, the acknowledge wins and the cycle ends normally.
- R9: On a write, `rw_o` is 0 for every phase of the cycle. `dout_oe` is 1 with `dout` equal to the write data from index 3 through 6+2n, and 0 otherwise.
- R10: `ready` returns to 1 on the clock after the last phase (S7, or S9 on the error path).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request |
| req_addr | input | ADDR_W | Byte address of the transfer |
| req_fc | input | FC_W | Function code for the transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | Sequencer idle, request may be given |
| done | output | 1 | One-clock pulse: cycle ended with acknowledge |
| err | output | 1 | One-clock pulse: cycle ended with bus error |
| rdata | output | DATA_W | Captured read data |
| fc_o | output | FC_W | Function code on the bus |
| addr_o | output | ADDR_W | Address on the bus |
| addr_oe | output | 1 | Address bus drive enable (0 = high impedance) |
| rw_o | output | 1 | Direction, 1 = read |
| as_n | output | 1 | Address strobe, active-low |
| uds_n | output | 1 | Upper data strobe, active-low |
| lds_n | output | 1 | Lower data strobe, active-low |
| dout | output | DATA_W | Write data to the bus |
| dout_oe | output | 1 | Write data drive enable |
| din | input | DATA_W | Read data from the bus |
| bus_ack_n | input | 1 | Data acknowledge, active-low |
| bus_err_n | input | 1 | Bus error, active-low |

## Verification
The hardest states to reach are the ones where timing depends on a response arriving late. Examples are a bus error that comes after several wait pairs, or an acknowledge and an error on the very same sample. The bench drives the acknowledge and error inputs at a chosen phase index, 4+2n, for each test. This places the response exactly at the n-th sampling edge. The bench also changes `din` one phase after the capture edge, and raises a second request partway through a cycle. These show that the capture happens at the right edge and that a request arriving while busy is ignored.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_S0, PH_S1, PH_S2, PH_S3, PH_S4,
      PH_S5, PH_S6, PH_S7, PH_S8, PH_S9,
      PH_WA, PH_WB
   } phase_t;

   function automatic logic strobe_phase(input phase_t p);
      return (p == PH_S2) || (p == PH_S3) || (p == PH_S4) || (p == PH_WA) ||
             (p == PH_WB) || (p == PH_S5) || (p == PH_S6);
   endfunction

   function automatic logic drive_phase(input phase_t p);
      return (p == PH_S3) || (p == PH_S4) || (p == PH_WA) || (p == PH_WB) ||
             (p == PH_S5) || (p == PH_S6);
   endfunction

endpackage

// File: rtl/hsb_timing.sv
module hsb_timing
   import hsb_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   ack_in,
   input  logic   berr_in,
   output phase_t phase,
   output logic   err_path
);

   phase_t nxt;
   logic   sample;

   assign sample = (phase == PH_S4) || (phase == PH_WB);

   always_comb begin
      nxt = phase;
      unique case (phase)
         PH_IDLE: nxt = start ? PH_S0 : PH_IDLE;
         PH_S0:   nxt = PH_S1;
         PH_S1:   nxt = PH_S2;
         PH_S2:   nxt = PH_S3;
         PH_S3:   nxt = PH_S4;
         PH_S4,
         PH_WB:   nxt = (ack_in || berr_in) ? PH_S5 : PH_WA;
         PH_WA:   nxt = PH_WB;
         PH_S5:   nxt = PH_S6;
         PH_S6:   nxt = PH_S7;
         PH_S7:   nxt = err_path ? PH_S8 : PH_IDLE;
         PH_S8:   nxt = PH_S9;
         PH_S9:   nxt = PH_IDLE;
         default: nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         err_path <= 1'b0;
      end else begin
         phase <= nxt;
         if (start)
            err_path <= 1'b0;
         else if (sample && berr_in && !ack_in)
            err_path <= 1'b1;
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && !start) |=> (phase == PH_IDLE)); // R2
   AST_WAIT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WA) |=> (phase == PH_WB)); // R6
   AST_NO_RESP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && !ack_in && !berr_in) |=> (phase == PH_WA)); // R6
   AST_TAIL_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_S8) |-> err_path); // R8

endmodule

// File: rtl/hsb_lanes.sv
module hsb_lanes #(
   parameter int N_LANES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic               word,
   input  logic               a0,
   output logic [N_LANES-1:0] strobe_n
);

   if (N_LANES != 2) begin : g_bad_lanes
      $error("hsb_lanes supports exactly two byte lanes");
   end

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      // lane 1 is the upper byte (even address), lane 0 the lower byte (odd address)
      localparam logic LANE_A0 = (i == 0);
      assign strobe_n[i] = !(active && (word || (a0 == LANE_A0)));
   end

   AST_LANE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (active && word) |-> (strobe_n == '0)); // R5
   AST_LANE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !word) |-> ($countones(~strobe_n) == 1)); // R5
   AST_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (strobe_n == '1)); // R1

endmodule

// File: rtl/hsb_datapath.sv
module hsb_datapath #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16,
   parameter int FC_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [FC_W-1:0]   req_fc,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] din,
   output logic [ADDR_W-1:0] addr_q,
   output logic [FC_W-1:0]   fc_q,
   output logic              write_q,
   output logic              word_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         fc_q    <= '0;
         write_q <= 1'b0;
         word_q  <= 1'b0;
         wdata_q <= '0;
      end else if (start) begin
         addr_q  <= req_addr;
         fc_q    <= req_fc;
         write_q <= req_write;
         word_q  <= req_word;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (capture)
         rdata_q <= din;
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(addr_q) && $stable(write_q) && $stable(word_q)); // R2

endmodule

// File: rtl/hsbus_master.sv
module hsbus_master
   import hsb_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16,
   parameter int FC_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [FC_W-1:0]   req_fc,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ready,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rdata,
   output logic [FC_W-1:0]   fc_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_oe,
   output logic              rw_o,
   output logic              as_n,
   output logic              uds_n,
   output logic              lds_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe,
   input  logic [DATA_W-1:0] din,
   input  logic              bus_ack_n,
   input  logic              bus_err_n
);

   localparam int N_LANES = 2;
   localparam int LANE_W  = DATA_W / N_LANES;

   if (DATA_W % N_LANES != 0 || LANE_W < 1) begin : g_bad_data
      $error("DATA_W must split into two equal byte lanes");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end
   if (FC_W < 1) begin : g_bad_fc
      $error("FC_W must be at least 1");
   end

   phase_t              phase;
   logic                err_path;
   logic                start;
   logic                busy;
   logic                stb_on;
   logic                capture;
   logic [ADDR_W-1:0]   addr_q;
   logic [FC_W-1:0]     fc_q;
   logic                write_q;
   logic                word_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [N_LANES-1:0]  lane_n;

   assign busy    = (phase != PH_IDLE);
   assign start   = req_valid && !busy;
   assign stb_on  = strobe_phase(phase);
   assign capture = (phase == PH_S6) && !write_q && !err_path;

   hsb_timing u_timing (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .ack_in   (!bus_ack_n),
      .berr_in  (!bus_err_n),
      .phase    (phase),
      .err_path (err_path)
   );

   hsb_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .FC_W   (FC_W)
   ) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_fc    (req_fc),
      .req_write (req_write),
      .req_word  (req_word),
      .req_wdata (req_wdata),
      .din       (din),
      .addr_q    (addr_q),
      .fc_q      (fc_q),
      .write_q   (write_q),
      .word_q    (word_q),
      .wdata_q   (wdata_q),
      .rdata_q   (rdata)
   );

   hsb_lanes #(
      .N_LANES (N_LANES)
   ) u_lanes (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (stb_on),
      .word     (word_q),
      .a0       (addr_q[0]),
      .strobe_n (lane_n)
   );

   assign ready   = !busy;
   assign done    = (phase == PH_S7) && !err_path;
   assign err     = (phase == PH_S9);
   assign fc_o    = busy ? fc_q : '0;
   assign rw_o    = busy ? !write_q : 1'b1;
   assign addr_o  = addr_q;
   assign addr_oe = busy && (phase != PH_S0);
   assign as_n    = !stb_on;
   assign uds_n   = lane_n[1];
   assign lds_n   = lane_n[0];
   assign dout    = wdata_q;
   assign dout_oe = write_q && drive_phase(phase);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> $stable(rdata)); // R7
   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err)); // R8
   AST_DRIVE_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe |-> !rw_o); // R9
   AST_STROBE_NEEDS_AS: assert property (@(posedge clk) disable iff (!rst_n)
      (!uds_n || !lds_n) |-> (!as_n && addr_oe)); // R4
   AST_AS_ADDR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !as_n |-> addr_oe); // R3
   AST_READY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |=> ready); // R10

endmodule

// File: tb/hsbus_master_tb.sv
module hsbus_master_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 24;
   localparam int DW = 16;
   localparam int FW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [FW-1:0] req_fc = '0;
   logic          req_write = 1'b0;
   logic          req_word = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic          ready, done, err, addr_oe, rw_o, as_n, uds_n, lds_n, dout_oe;
   logic [DW-1:0] rdata, dout;
   logic [FW-1:0] fc_o;
   logic [AW-1:0] addr_o;
   logic [DW-1:0] din = 16'h0bad;
   logic          bus_ack_n = 1'b1;
   logic          bus_err_n = 1'b1;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hsbus_master u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_fc(req_fc), .req_write(req_write), .req_word(req_word),
      .req_wdata(req_wdata), .ready(ready), .done(done), .err(err),
      .rdata(rdata), .fc_o(fc_o), .addr_o(addr_o), .addr_oe(addr_oe),
      .rw_o(rw_o), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n), .dout(dout),
      .dout_oe(dout_oe), .din(din), .bus_ack_n(bus_ack_n), .bus_err_n(bus_err_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 as_n in reset", as_n, 1);
      chk("R1 uds_n in reset", uds_n, 1);
      chk("R1 lds_n in reset", lds_n, 1);
      chk("R1 addr_oe in reset", addr_oe, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready idle", ready, 1);
      chk("R1 rw_o idle", rw_o, 1);
      chk("R1 done/err idle", {done, err, dout_oe}, 0);
   endtask

   // mode: 0 = acknowledge, 1 = bus error only, 2 = both on the same sample
   task automatic run_xfer(input logic [AW-1:0] a, input logic [FW-1:0] f,
                           input logic wr, input logic wd, input logic [DW-1:0] wdat,
                           input logic [DW-1:0] rval, input int n, input int mode,
                           input bit inject);
      int last;
      int s7;
      logic exp_u, exp_l;
      last = (mode == 1) ? 9 + 2*n : 7 + 2*n;
      s7 = 7 + 2*n;
      exp_u = wd || (a[0] == 1'b0);
      exp_l = wd || (a[0] == 1'b1);
      din = 16'h0bad;
      req_addr = a; req_fc = f; req_write = wr; req_word = wd; req_wdata = wdat;
      req_valid = 1'b1;
      @(negedge clk);
      for (int j = 0; j <= last + 1; j++) begin
         bit stb;
         if (j > 0) @(negedge clk);
         stb = (j >= 2) && (j <= 6 + 2*n);
         chk("R4 as_n", as_n, !stb);
         chk("R5 uds_n", uds_n, !(stb && exp_u));
         chk("R5 lds_n", lds_n, !(stb && exp_l));
         chk("R3 addr_oe", addr_oe, (j >= 1) && (j <= last));
         chk("R9 dout_oe", dout_oe, wr && (j >= 3) && (j <= 6 + 2*n));
         chk("R9 rw_o", rw_o, (j <= last) ? !wr : 1'b1);
         chk("R7 done", done, (mode != 1) && (j == s7));
         chk("R8 err", err, (mode == 1) && (j == last));
         chk("R10 ready", ready, j > last);
         if (j == 0) chk("R3 fc_o in S0", fc_o, f);
         if (j == 1 || j == 5) chk("R2 addr_o", addr_o, a);
         if (wr && j == 4) chk("R9 dout value", dout, wdat);
         if (!wr && mode != 1 && j == s7) chk("R7 rdata", rdata, rval);
         // drive for next edge
         if (j == 0) req_valid = 1'b0;
         if (inject && j == 3) begin req_valid = 1'b1; req_addr = ~a; end
         if (inject && j == 4) begin req_valid = 1'b0; req_addr = a; end
         if (j == 4 + 2*n) begin
            bus_ack_n = (mode == 1);
            bus_err_n = (mode == 0);
         end
         if (j == 6 + 2*n) din = rval;
         if (j == s7) begin
            din = ~rval;
            bus_ack_n = 1'b1;
            bus_err_n = 1'b1;
         end
      end
      if (!wr && mode != 1) chk("R7 rdata held", rdata, rval);
   endtask

   task automatic test_busy_ignore();
      run_xfer(24'h001234, 3'd5, 1'b0, 1'b1, 16'h0, 16'h5a5a, 1, 0, 1'b1);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R2 no second cycle as_n", as_n, 1);
         chk("R2 no second cycle ready", ready, 1);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R10: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      test_reset();
      run_xfer(24'h000100, 3'd6, 1'b0, 1'b1, 16'h0,    16'h1357, 0, 0, 1'b0); // R6 no wait
      run_xfer(24'h000202, 3'd1, 1'b0, 1'b0, 16'h0,    16'h2468, 2, 0, 1'b0); // R5 even byte
      run_xfer(24'h000303, 3'd2, 1'b0, 1'b0, 16'h0,    16'h9abc, 1, 0, 1'b0); // R5 odd byte
      run_xfer(24'h000400, 3'd5, 1'b1, 1'b1, 16'hc0de, 16'h0,    0, 0, 1'b0); // R9 word write
      run_xfer(24'h000501, 3'd1, 1'b1, 1'b0, 16'h00a5, 16'h0,    3, 0, 1'b0); // R9 byte write
      run_xfer(24'h000600, 3'd6, 1'b0, 1'b1, 16'h0,    16'h0,    1, 1, 1'b0); // R8 error read
      run_xfer(24'h000700, 3'd6, 1'b0, 1'b1, 16'h0,    16'h7777, 0, 2, 1'b0); // R8 both
      run_xfer(24'h000802, 3'd2, 1'b1, 1'b0, 16'h3300, 16'h0,    0, 1, 1'b0); // R8 error write
      test_busy_ignore();                                                     // R2
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule